// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine with Self-Test

This block computes a 16-bit cyclic redundancy check over a stream of bytes delivered one at a time through a small synchronous register interface. Software first clears the engine by setting the top bit of the control register. It then writes payload bytes, one per write, to the data register. When the payload is done it reads the checksum from the result register. The low bits of the control register report how many bytes have been taken in since the last clear, so software can confirm that no write was lost.

The arithmetic uses the generator x^16 + x^12 + x^5 + 1 and consumes each byte least-significant bit first, as serial infrared and HDLC framing do. The running register starts at all ones. The value presented at the result register is the running register XORed with a fixed output mask. That mask is derived at elaboration so that a known four-byte power-on vector reproduces a known checksum. Driver software checks this vector to prove the engine is working before it trusts the engine with traffic.

Each accepted write updates the engine in one clock. Reads are combinational from the register state, so a value written on one clock edge can be read back in the following cycle.

Top module: `crc16_engine`

## Requirements
- R1: While `rst` is high, and after it is released, the byte count is 0 and the result register shows the all-ones starting value XORed with the output mask.
- R2: A write to the control register (address 0) with bit 15 set returns the running CRC to its starting value and clears the byte count. Both changes are visible in the next cycle.
- R3: Bit 15 of the control register always reads as 0. A control write with bit 15 clear changes neither the count nor the result.
- R4: A write to the data register (address 1) feeds only bits 7:0 into the CRC. Bits 15:8 of that write have no effect on the result.
- R5: Each data write raises the byte count by one. The count reads back in bits 11:0 of the control register, and bits 15:12 read as 0.
- R6: The CRC uses the generator 0x1021 applied least-significant bit first (reflected constant 0x8408), with a starting value of 0xFFFF. The result register shows the running value XORed with a fixed 16-bit mask.
- R7: After a clear, the bytes 0xCC, 0xF5, 0xF1, 0xA7 fed in that order give a count of 4 and a result of 0x51DF.
- R8: The byte count holds at 0xFFF once it gets there. Further data writes still update the CRC but leave the count at 0xFFF.
- R9: The result register (address 2) holds its value in any cycle without a control or data write. Writes to address 2 or 3 have no effect. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | 2 | Write address: 0 control, 1 data, 2 result, 3 unused |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Combinational read data for `rd_addr` |

## Verification
The CRC state and the byte counter are both visible through reads, so almost any internal fault shows up at `rd_data` in the cycle right after the write that caused it. A counter that drops, doubles or wraps an increment is seen in the control register on the next read. It is especially visible at the 0xFFF limit, where wrapping would read back as a small number. A wrong bit order, polynomial, starting value or mask changes the result after the first byte. A clear that misses the running register cannot be masked by the self-test, because the test compares against a fixed value from a fixed starting point.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int CRC_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int CNT_W    = 12;
    localparam int CLR_BIT  = 15;

    typedef logic [CRC_W-1:0] crc_t;

    localparam crc_t POLY_REFL = 16'h8408;
    localparam crc_t CRC_START = 16'hFFFF;

    localparam logic [31:0] SELFTEST_BYTES  = 32'hCCF5_F1A7;
    localparam crc_t        SELFTEST_RESULT = 16'h51DF;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_RESULT = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              clear;
        logic              feed;
        logic [BYTE_W-1:0] byte_val;
    } eng_cmd_t;

    function automatic crc_t crc_bit(crc_t state, logic din);
        logic fb;
        fb = state[0] ^ din;
        return fb ? ((state >> 1) ^ POLY_REFL) : (state >> 1);
    endfunction

    function automatic crc_t crc_byte(crc_t state, logic [BYTE_W-1:0] b);
        crc_t s;
        s = state;
        for (int i = 0; i < BYTE_W; i++) begin
            s = crc_bit(s, b[i]);
        end
        return s;
    endfunction

    function automatic crc_t crc_word32(crc_t state, logic [31:0] bytes);
        crc_t s;
        s = state;
        for (int k = 3; k >= 0; k--) begin
            s = crc_byte(s, bytes[k*8 +: 8]);
        end
        return s;
    endfunction

    localparam crc_t OUT_MASK = crc_word32(CRC_START, SELFTEST_BYTES) ^ SELFTEST_RESULT;

endpackage

// File: rtl/crc16_reg_decode.sv
module crc16_reg_decode
    import crc16_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output eng_cmd_t          cmd
);
    reg_sel_e sel;

    always_comb begin
        sel          = reg_sel_e'(wr_addr);
        cmd.clear    = 1'b0;
        cmd.feed     = 1'b0;
        cmd.byte_val = wr_data[BYTE_W-1:0];
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL:   cmd.clear = wr_data[CLR_BIT];
                SEL_DATA:   cmd.feed  = 1'b1;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/crc16_byte_unit.sv
module crc16_byte_unit
    import crc16_pkg::*;
#(
    parameter crc_t POLY  = POLY_REFL,
    parameter crc_t START = CRC_START,
    parameter int   BITS  = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            feed,
    input  logic [BITS-1:0] byte_val,
    output crc_t            state
);
    crc_t stage [0:BITS];
    crc_t state_q;

    assign stage[0] = state_q;

    for (genvar g = 0; g < BITS; g++) begin : g_bit
        logic fb;
        assign fb           = stage[g][0] ^ byte_val[g];
        assign stage[g + 1] = fb ? ((stage[g] >> 1) ^ POLY) : (stage[g] >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q <= START;
        end else if (feed) begin
            state_q <= stage[BITS];
        end
    end

    assign state = state_q;
endmodule

// File: rtl/crc16_byte_counter.sv
module crc16_byte_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (inc && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/crc16_read_mux.sv
module crc16_read_mux
    import crc16_pkg::*;
(
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  count,
    input  crc_t              result,
    output logic [15:0]       rd_data
);
    reg_sel_e sel;

    always_comb begin
        sel = reg_sel_e'(rd_addr);
        unique case (sel)
            SEL_CTRL:   rd_data = {{(16-CNT_W){1'b0}}, count};
            SEL_DATA:   rd_data = '0;
            SEL_RESULT: rd_data = result;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
    import crc16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [15:0] rd_data
);
    eng_cmd_t         cmd;
    crc_t             crc_state;
    crc_t             result;
    logic [CNT_W-1:0] count;

    crc16_reg_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    crc16_byte_unit #(
        .POLY  (POLY_REFL),
        .START (CRC_START),
        .BITS  (BYTE_W)
    ) u_crc (
        .clk      (clk),
        .rst      (rst),
        .clear    (cmd.clear),
        .feed     (cmd.feed),
        .byte_val (cmd.byte_val),
        .state    (crc_state)
    );

    crc16_byte_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cmd.clear),
        .inc   (cmd.feed),
        .count (count)
    );

    assign result = crc_state ^ OUT_MASK;

    crc16_read_mux u_rd (
        .rd_addr (rd_addr),
        .count   (count),
        .result  (result),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/crc16_engine_checker.sv
module crc16_engine_checker
    import crc16_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [15:0]      wr_data,
    input logic [1:0]       rd_addr,
    input logic [15:0]      rd_data,
    input logic [CNT_W-1:0] count,
    input crc_t             result
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic ctrl_wr, data_wr;
    assign ctrl_wr = wr_en && (wr_addr == 2'd0);
    assign data_wr = wr_en && (wr_addr == 2'd1);

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_data[CLR_BIT]) |=> (count == '0) && (result == (CRC_START ^ OUT_MASK)));

    assert_ctrl_noeffect_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wr_data[CLR_BIT]) |=> $stable(count) && $stable(result));

    assert_ctrl_bit15_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 2'd0) |-> (rd_data[15] == 1'b0));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (data_wr && count != CMAX) |=> (count == $past(count) + 1'b1));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (data_wr && count == CMAX) |=> (count == CMAX));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_wr || data_wr) |=> $stable(result) && $stable(count));
endmodule

bind crc16_engine crc16_engine_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .count   (count),
    .result  (result)
);

// File: tb/crc16_engine_test.sv
module crc16_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] model;   // reference running value
    logic [15:0] mask;
    int          model_cnt;

    always #10 clk = ~clk;

    crc16_engine uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [15:0] ref_byte(logic [15:0] s, logic [7:0] b);
        logic [15:0] r;
        r = s;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd1) begin
            model = ref_byte(model, d[7:0]);
            if (model_cnt < 4095) model_cnt++;
        end else if (a == 2'd0 && d[15]) begin
            model = 16'hFFFF;
            model_cnt = 0;
        end
    endtask

    task automatic check_state(string req);
        logic [15:0] v;
        rd(2'd0, v);
        check(req, "count", v, 16'(model_cnt));
        rd(2'd2, v);
        check(req, "result", v, model ^ mask);
    endtask

    task automatic t_reset_R1;
        @(negedge clk);
        check_state("R1");
    endtask

    task automatic t_selftest_R7;
        logic [15:0] v;
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'h00CC);
        wr(2'd1, 16'h00F5);
        wr(2'd1, 16'h00F1);
        wr(2'd1, 16'h00A7);
        rd(2'd0, v); check("R7", "selftest count", v, 16'd4);
        rd(2'd2, v); check("R7", "selftest result", v, 16'h51DF);
        check_state("R6");
    endtask

    task automatic t_clear_R2;
        wr(2'd1, 16'h0055);
        wr(2'd0, 16'h8ABC);
        check_state("R2");
        check("R2", "clear result direct", (16'hFFFF ^ mask), model ^ mask);
    endtask

    task automatic t_ctrl_R3;
        logic [15:0] v;
        wr(2'd1, 16'h0031);
        wr(2'd1, 16'h0032);
        wr(2'd0, 16'h7FFF);
        check_state("R3");
        rd(2'd0, v); check("R3", "bit15 reads 0", {15'd0, v[15]}, 16'd0);
    endtask

    task automatic t_upper_R4;
        logic [15:0] v, r1;
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'hAB12);
        rd(2'd2, r1);
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'h0012);
        rd(2'd2, v);
        check("R4", "upper bits ignored", v, r1);
        check_state("R4");
    endtask

    task automatic t_count_R5;
        logic [15:0] v;
        wr(2'd0, 16'h8000);
        for (int i = 0; i < 7; i++) wr(2'd1, 16'(i * 37));
        rd(2'd0, v);
        check("R5", "count after 7", v, 16'd7);
        check("R5", "count upper bits", v & 16'hF000, 16'h0000);
        check_state("R6");
    endtask

    task automatic t_idle_R9;
        logic [15:0] v;
        wr(2'd1, 16'h00E7);
        repeat (5) @(negedge clk);
        check_state("R9");
        wr(2'd2, 16'h1234);
        wr(2'd3, 16'hFFFF);
        check_state("R9");
        rd(2'd3, v); check("R9", "spare read", v, 16'h0000);
    endtask

    task automatic t_saturate_R8;
        logic [15:0] v;
        wr(2'd0, 16'h8000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1;
        for (int i = 0; i < 4100; i++) begin
            wr_data = 16'(i);
            model = ref_byte(model, 8'(i));
            if (model_cnt < 4095) model_cnt++;
            @(negedge clk);
            if (i == 4093) begin
                rd(2'd0, v); check("R8", "count before limit", v, 16'hFFE);
            end
        end
        wr_en = 1'b0;
        rd(2'd0, v); check("R8", "count held", v, 16'h0FFF);
        check_state("R8");
    endtask

    initial begin
        model = 16'hFFFF;
        model_cnt = 0;
        mask = 16'hFFFF;
        mask = ref_byte(mask, 8'hCC);
        mask = ref_byte(mask, 8'hF5);
        mask = ref_byte(mask, 8'hF1);
        mask = ref_byte(mask, 8'hA7);
        mask = mask ^ 16'h51DF;
        repeat (3) @(negedge clk);
        check_state("R1");
        rst = 1'b0;
        t_reset_R1();
        t_selftest_R7();
        t_clear_R2();
        t_ctrl_R3();
        t_upper_R4();
        t_count_R5();
        t_idle_R9();
        t_saturate_R8();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule